// File: doc/BRIEF.md
# SD/MMC command line engine

This block owns the single bidirectional command wire between a host controller and an MMC or SD card running in native mode. When it is given a 6-bit command index and a 32-bit argument, it builds a 48-bit command token, protects it with a 7-bit CRC, and shifts it out most significant bit first, one bit for each pulse of a bit-clock enable. It then stops driving the wire and lets the card turn the line around. It then waits a programmable number of bit times for the card's start bit. Depending on the response type chosen for that command, it captures a 48-bit or a 136-bit reply and checks its CRC. It can also finish right after the token when no reply is expected.

The surrounding controller generates the card clock and supplies `bit_en`, which is high for one clock cycle per card bit. It pulses `start` with the command fields set up, and then waits for the one-cycle `done` pulse. `timeout_err` and `crc_err` stay valid from that pulse until the next accepted start. `rsp_data` keeps the last captured reply until another reply completes. The block has no streaming interface and no back-pressure. A `start` pulse is accepted only while `busy` is low, and a pulse while busy is dropped. The pad logic uses `cmd_oe` to select between driving `cmd_out` and sampling `cmd_in`.

Top module: `sdcmd_engine`

## Requirements
- R1: After reset, cmd_oe=1, cmd_out=1, busy=0, done=0, timeout_err=0, crc_err=0 and rsp_data=0.
- R2: An accepted start sends 48 bits, most significant first: 0, 1, the index (6 bits), the argument (32 bits), CRC7 (generator x^7+x^3+1, zero initial value) over the preceding 40 bits, and a final 1. The first bit is on cmd_out from the cycle after start. Each later bit appears after the next bit_en, so an index of 0 with an argument of 0 carries the CRC 7'h4A.
- R3: After the 48th bit_en of the token, cmd_oe goes low for a reply type, or done pulses with cmd_oe kept high when no reply is expected. While idle and sending, the engine drives cmd_out high except for the token bits.
- R4: rsp_kind is latched at start: 0 = no reply, 1 = 48-bit reply with CRC check, 2 = 48-bit reply without CRC check, 3 = 136-bit reply with CRC check.
- R5: The first 2 bit_en samples after release are turnaround and are ignored, even when they are 0. The reply start bit is the first later sample that is 0.
- R6: With limit N = rsp_timeout latched at start (0 acts as 1), the engine pulses done with timeout_err=1 on the N-th high sample after turnaround if no start bit has appeared. A start bit on sample N or earlier is accepted.
- R7: A 48-bit reply is placed in rsp_data[47:0] with the start bit at bit 47, and rsp_data[135:48] is 0.
- R8: A 136-bit reply fills rsp_data[135:0] with the start bit at bit 135.
- R9: For type 1, crc_err is set at done if the CRC7 over the first 40 reply bits differs from reply bits 40..46. For type 2, crc_err stays 0.
- R10: For type 3, the CRC7 covers reply bits 8..127 (bit 0 is the start bit) and is compared with bits 128..134.
- R11: A start pulse while busy has no effect on the token being sent or on the reply handling.
- R12: With bit_en low, cmd_out, cmd_oe and the progress of the transfer hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle pulse per card bit time |
| start | input | 1 | Command start strobe, taken when idle |
| cmd_idx | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | Expected reply type (see R4) |
| rsp_timeout | input | TMO_W | Reply wait limit in bit times |
| cmd_in | input | 1 | Sampled command wire |
| cmd_out | output | 1 | Value to drive on the command wire |
| cmd_oe | output | 1 | Drive enable for the command wire |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | No start bit in time |
| crc_err | output | 1 | Reply CRC mismatch |
| rsp_data | output | 136 | Captured reply, right-aligned |

## Verification
The bench builds the block with TMO_W=16 and TURN_CLKS=2. A 16-bit limit keeps small values such as 0, 1 and 5 in reach, so the timeout can be checked on both sides of its edge within a few dozen bit times. With two turnaround clocks, the fake card can place zeros in the turnaround slots and show that they are not taken as a start bit. Three bit_en patterns (every cycle, every third cycle, and pseudo-random) show that the wire and the counters hold still between enables.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;
  localparam int TOKEN_BITS     = 48;
  localparam int SHORT_BITS     = 48;
  localparam int LONG_BITS      = 136;
  localparam int IDX_BITS       = 6;
  localparam int ARG_BITS       = 32;
  localparam int CRC_BITS       = 7;
  localparam int HEAD_BITS      = 2 + IDX_BITS + ARG_BITS;
  localparam int SHORT_CRC_SPAN = 40;
  localparam int LONG_CRC_FIRST = 8;
  localparam int LONG_CRC_LAST  = 127;
  localparam logic [CRC_BITS-1:0] CRC_TAPS = 7'h09;

  typedef enum logic [1:0] {
    RSP_NONE      = 2'd0,
    RSP_SHORT     = 2'd1,
    RSP_SHORT_RAW = 2'd2,
    RSP_LONG      = 2'd3
  } rsp_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_TURN,
    ST_LISTEN,
    ST_CAPT
  } line_state_e;

  function automatic logic [CRC_BITS-1:0] crc7_step(input logic [CRC_BITS-1:0] c,
                                                     input logic b);
    logic fb;
    fb = b ^ c[CRC_BITS-1];
    return {c[CRC_BITS-2:0], 1'b0} ^ (fb ? CRC_TAPS : '0);
  endfunction

  function automatic logic [CRC_BITS-1:0] crc7_head(input logic [HEAD_BITS-1:0] d);
    logic [CRC_BITS-1:0] c;
    c = '0;
    for (int i = HEAD_BITS - 1; i >= 0; i--) c = crc7_step(c, d[i]);
    return c;
  endfunction
endpackage

// File: rtl/sdcmd_crc7.sv
module sdcmd_crc7
  import sdcmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                en,
  input  logic                din,
  output logic [CRC_BITS-1:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) crc <= '0;
    else if (en)       crc <= crc7_step(crc, din);
  end
endmodule

// File: rtl/sdcmd_tx_token.sv
module sdcmd_tx_token
  import sdcmd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [IDX_BITS-1:0] idx,
  input  logic [ARG_BITS-1:0] arg,
  input  logic                shift,
  output logic                bit_out,
  output logic                last
);
  localparam int CW = $clog2(TOKEN_BITS);

  logic [TOKEN_BITS-1:0] sh;
  logic [CW-1:0]         cnt;
  logic [HEAD_BITS-1:0]  head;

  assign head    = {2'b01, idx, arg};
  assign bit_out = sh[TOKEN_BITS-1];
  assign last    = (cnt == CW'(TOKEN_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh  <= '1;
      cnt <= '0;
    end else if (load) begin
      sh  <= {head, crc7_head(head), 1'b1};
      cnt <= '0;
    end else if (shift) begin
      sh  <= {sh[TOKEN_BITS-2:0], 1'b1};
      cnt <= cnt + 1'b1;
    end
  end

  assert_start_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !bit_out);
endmodule

// File: rtl/sdcmd_wait_timer.sv
module sdcmd_wait_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] limit,
  output logic         expired
);
  logic [W:0] cnt;
  logic [W:0] eff;

  assign eff     = (limit == '0) ? (W+1)'(1) : {1'b0, limit};
  assign expired = step && ((cnt + 1'b1) >= eff);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (step)     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/sdcmd_engine.sv
module sdcmd_engine
  import sdcmd_pkg::*;
#(
  parameter int TMO_W     = 16,
  parameter int TURN_CLKS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bit_en,
  input  logic                 start,
  input  logic [IDX_BITS-1:0]  cmd_idx,
  input  logic [ARG_BITS-1:0]  cmd_arg,
  input  logic [1:0]           rsp_kind,
  input  logic [TMO_W-1:0]     rsp_timeout,
  input  logic                 cmd_in,
  output logic                 cmd_out,
  output logic                 cmd_oe,
  output logic                 busy,
  output logic                 done,
  output logic                 timeout_err,
  output logic                 crc_err,
  output logic [LONG_BITS-1:0] rsp_data
);
  localparam int RXC_W = $clog2(LONG_BITS);
  localparam int TC_W  = (TURN_CLKS > 1) ? $clog2(TURN_CLKS) : 1;

  line_state_e          state_q;
  rsp_kind_e            kind_q;
  logic [TMO_W-1:0]     lim_q;
  logic [TC_W-1:0]      turn_cnt;
  logic [RXC_W-1:0]     rx_cnt;
  logic [LONG_BITS-2:0] rx_sh;

  logic                tx_load, tx_shift, tx_bit, tx_last;
  logic                listen_step, tmo_hit;
  logic                crc_en, crc_check, crc_bad, in_range, rx_last;
  logic [CRC_BITS-1:0] crc_val;
  logic [RXC_W-1:0]    rx_final;

  always_comb begin
    tx_load     = (state_q == ST_IDLE) && start;
    tx_shift    = (state_q == ST_SEND) && bit_en;
    listen_step = (state_q == ST_LISTEN) && bit_en && cmd_in;
    rx_final    = (kind_q == RSP_LONG) ? RXC_W'(LONG_BITS - 1) : RXC_W'(SHORT_BITS - 1);
    rx_last     = (rx_cnt == rx_final);
    if (kind_q == RSP_LONG)
      in_range = (rx_cnt >= RXC_W'(LONG_CRC_FIRST)) && (rx_cnt <= RXC_W'(LONG_CRC_LAST));
    else
      in_range = (rx_cnt < RXC_W'(SHORT_CRC_SPAN));
    crc_en    = bit_en && (((state_q == ST_LISTEN) && !cmd_in && (kind_q != RSP_LONG)) ||
                           ((state_q == ST_CAPT) && in_range));
    crc_check = (kind_q == RSP_SHORT) || (kind_q == RSP_LONG);
    crc_bad   = (crc_val != rx_sh[CRC_BITS-1:0]);
    cmd_out   = (state_q == ST_SEND) ? tx_bit : 1'b1;
    cmd_oe    = (state_q == ST_IDLE) || (state_q == ST_SEND);
    busy      = (state_q != ST_IDLE);
  end

  sdcmd_tx_token u_tx (
    .clk(clk), .rst_n(rst_n), .load(tx_load), .idx(cmd_idx), .arg(cmd_arg),
    .shift(tx_shift), .bit_out(tx_bit), .last(tx_last)
  );

  sdcmd_crc7 u_crc (
    .clk(clk), .rst_n(rst_n), .clr(tx_load), .en(crc_en), .din(cmd_in), .crc(crc_val)
  );

  sdcmd_wait_timer #(.W(TMO_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(state_q != ST_LISTEN), .step(listen_step),
    .limit(lim_q), .expired(tmo_hit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      kind_q      <= RSP_NONE;
      lim_q       <= '0;
      turn_cnt    <= '0;
      rx_cnt      <= '0;
      rx_sh       <= '0;
      rsp_data    <= '0;
      done        <= 1'b0;
      timeout_err <= 1'b0;
      crc_err     <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q     <= ST_SEND;
          kind_q      <= rsp_kind_e'(rsp_kind);
          lim_q       <= rsp_timeout;
          timeout_err <= 1'b0;
          crc_err     <= 1'b0;
          rx_sh       <= '0;
        end
        ST_SEND: if (bit_en && tx_last) begin
          if (kind_q == RSP_NONE) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end else begin
            state_q  <= ST_TURN;
            turn_cnt <= '0;
          end
        end
        ST_TURN: if (bit_en) begin
          turn_cnt <= turn_cnt + 1'b1;
          if (turn_cnt == TC_W'(TURN_CLKS - 1)) state_q <= ST_LISTEN;
        end
        ST_LISTEN: if (bit_en) begin
          if (!cmd_in) begin
            state_q <= ST_CAPT;
            rx_sh   <= {rx_sh[LONG_BITS-3:0], 1'b0};
            rx_cnt  <= RXC_W'(1);
          end else if (tmo_hit) begin
            timeout_err <= 1'b1;
            done        <= 1'b1;
            state_q     <= ST_IDLE;
          end
        end
        ST_CAPT: if (bit_en) begin
          rx_sh  <= {rx_sh[LONG_BITS-3:0], cmd_in};
          rx_cnt <= rx_cnt + 1'b1;
          if (rx_last) begin
            rsp_data <= {rx_sh, cmd_in};
            crc_err  <= crc_check && crc_bad;
            done     <= 1'b1;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_flag_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !(timeout_err && crc_err));

  assert_stall_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_en) |=> ($stable(cmd_out) && $stable(cmd_oe)));

  assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cmd_oe) |-> $past(bit_en));

  assert_timeout_origin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_err) |-> $past(state_q == ST_LISTEN));
endmodule

// File: tb/sim_sdcmd_engine.sv
module sim_sdcmd_engine;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         rst_n = 1'b0, bit_en = 1'b0, start = 1'b0, cmd_in = 1'b1;
  logic [5:0]   cmd_idx = '0;
  logic [31:0]  cmd_arg = '0;
  logic [1:0]   rsp_kind = '0;
  logic [15:0]  rsp_timeout = '0;
  logic         cmd_out, cmd_oe, busy, done, timeout_err, crc_err;
  logic [135:0] rsp_data;

  sdcmd_engine #(.TMO_W(16), .TURN_CLKS(2)) u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .start(start), .cmd_idx(cmd_idx),
    .cmd_arg(cmd_arg), .rsp_kind(rsp_kind), .rsp_timeout(rsp_timeout), .cmd_in(cmd_in),
    .cmd_out(cmd_out), .cmd_oe(cmd_oe), .busy(busy), .done(done),
    .timeout_err(timeout_err), .crc_err(crc_err), .rsp_data(rsp_data)
  );

  int errors = 0, checks = 0, cyc = 0;
  bit fin = 0;

  task automatic check(input bit ok, input string tag, input logic [135:0] act,
                       input logic [135:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // polynomial long division remainder, message MSB first in v[n-1:0]
  function automatic bit [6:0] crc_bits(input bit [135:0] v, input int n);
    bit arr [0:143];
    bit [7:0] g;
    bit [6:0] r;
    g = 8'h89;
    for (int i = 0; i < 144; i++) arr[i] = 1'b0;
    for (int i = 0; i < n; i++) arr[i] = v[n-1-i];
    for (int i = 0; i < n; i++)
      if (arr[i]) for (int j = 0; j < 8; j++) arr[i+j] = arr[i+j] ^ g[7-j];
    for (int k = 0; k < 7; k++) r[6-k] = arr[n+k];
    return r;
  endfunction

  // ---------------- bit enable patterns ----------------
  int en_mode = 0, div = 0;
  bit [7:0] lfsr = 8'hA5;
  always @(negedge clk) begin
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    div  = (div == 2) ? 0 : div + 1;
    case (en_mode)
      0: bit_en = 1'b1;
      1: bit_en = (div == 2);
      default: bit_en = lfsr[0];
    endcase
  end

  // ---------------- card model ----------------
  bit cq[$];
  bit card_armed = 0, card_active = 0, consumed = 0;
  always @(posedge clk) if (card_active && bit_en) consumed = 1;
  always @(negedge clk) begin
    if (consumed) begin
      if (cq.size() > 0) void'(cq.pop_front());
      consumed = 0;
    end
    if (card_armed && !cmd_oe) begin
      card_active = 1;
      card_armed  = 0;
    end
    cmd_in = (card_active && cq.size() > 0) ? cq[0] : 1'b1;
  end

  // ---------------- token monitor ----------------
  bit tx_log[$];
  always @(posedge clk) if (rst_n && busy && cmd_oe && bit_en) tx_log.push_back(cmd_out);

  // ---------------- cycle reference model ----------------
  int m_state = 0, m_n = 0, m_lim = 1, m_L = 48;
  bit m_done = 0, m_to = 0, m_ce = 0;
  bit [1:0] m_kind = 0;
  bit [135:0] m_rsp = '0, m_rv;
  bit [47:0] m_tok;
  bit m_txq[$], m_rxq[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_done = 0; m_to = 0; m_ce = 0; m_rsp = '0;
      m_txq.delete(); m_rxq.delete();
    end else begin
      m_done = 0;
      case (m_state)
        0: if (start) begin
          m_tok = {2'b01, cmd_idx, cmd_arg, crc_bits(136'({2'b01, cmd_idx, cmd_arg}), 40), 1'b1};
          m_txq.delete();
          for (int i = 47; i >= 0; i--) m_txq.push_back(m_tok[i]);
          m_kind = rsp_kind;
          m_lim  = (rsp_timeout == 0) ? 1 : int'(rsp_timeout);
          m_to = 0; m_ce = 0; m_state = 1;
        end
        1: if (bit_en) begin
          void'(m_txq.pop_front());
          if (m_txq.size() == 0) begin
            if (m_kind == 0) begin m_state = 0; m_done = 1; end
            else begin m_state = 2; m_n = 0; end
          end
        end
        2: if (bit_en) begin
          m_n++;
          if (m_n == 2) begin m_state = 3; m_n = 0; end
        end
        3: if (bit_en) begin
          if (!cmd_in) begin
            m_rxq.delete(); m_rxq.push_back(1'b0); m_state = 4;
          end else begin
            m_n++;
            if (m_n >= m_lim) begin m_to = 1; m_done = 1; m_state = 0; end
          end
        end
        4: if (bit_en) begin
          m_rxq.push_back(cmd_in);
          m_L = (m_kind == 3) ? 136 : 48;
          if (m_rxq.size() == m_L) begin
            m_rv = '0;
            for (int i = 0; i < m_L; i++) m_rv[m_L-1-i] = m_rxq[i];
            m_rsp = m_rv;
            if (m_kind == 1) m_ce = (crc_bits(136'(m_rv[47:8]), 40) != m_rv[7:1]);
            else if (m_kind == 3) m_ce = (crc_bits(136'(m_rv[127:8]), 120) != m_rv[7:1]);
            else m_ce = 0;
            m_done = 1; m_state = 0;
          end
        end
        default: m_state = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !fin) begin
      check(cmd_out == ((m_state == 1) ? m_txq[0] : 1'b1), "R2/R12 cmd_out", 136'(cmd_out),
            136'((m_state == 1) ? m_txq[0] : 1'b1));
      check(cmd_oe == (m_state <= 1), "R3/R12 cmd_oe", 136'(cmd_oe), 136'(m_state <= 1));
      check(busy == (m_state != 0), "R11 busy", 136'(busy), 136'(m_state != 0));
      check(done == m_done, "R6 done", 136'(done), 136'(m_done));
      check(timeout_err == m_to, "R6 timeout_err", 136'(timeout_err), 136'(m_to));
      check(crc_err == m_ce, "R9 crc_err", 136'(crc_err), 136'(m_ce));
      check(rsp_data == m_rsp, "R7 rsp_data", rsp_data, m_rsp);
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ---------------- directed transaction ----------------
  bit [47:0] last_tok;

  task automatic run(input bit [5:0] idx, input bit [31:0] arg, input bit [1:0] kind,
                     input bit [15:0] lim, input int delay, input bit bad,
                     input bit silent, input bit poke, input int mode, input string tag);
    bit [135:0] rv;
    bit [47:0] tok, got;
    int L, eff;
    bit exp_to, exp_ce;
    rv = '0;
    L  = (kind == 3) ? 136 : 48;
    if (kind == 3) begin
      rv = {2'b00, 6'h3F, arg, ~arg, arg ^ 32'h5A5A_C3C3, arg[23:0], 7'b0, 1'b1};
      rv[7:1] = crc_bits(136'(rv[127:8]), 120) ^ {6'b0, bad};
    end else begin
      rv[47:0] = {2'b00, idx, ~arg, 7'b0, 1'b1};
      rv[7:1] = crc_bits(136'(rv[47:8]), 40) ^ {6'b0, bad};
    end
    eff    = (lim == 0) ? 1 : int'(lim);
    exp_to = (kind != 0) && (silent || delay >= eff);
    exp_ce = !exp_to && bad && (kind == 1 || kind == 3);
    tok    = {2'b01, idx, arg, crc_bits(136'({2'b01, idx, arg}), 40), 1'b1};

    @(negedge clk);
    en_mode = mode;
    cq.delete();
    if (kind != 0) begin
      cq.push_back(1'b0); cq.push_back(1'b0);   // turnaround slots driven low
      if (!silent) begin
        for (int i = 0; i < delay; i++) cq.push_back(1'b1);
        for (int i = L - 1; i >= 0; i--) cq.push_back(rv[i]);
      end
    end
    tx_log.delete();
    card_armed = (kind != 0);
    cmd_idx = idx; cmd_arg = arg; rsp_kind = kind; rsp_timeout = lim;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      repeat (6) @(negedge clk);
      cmd_idx = ~idx; cmd_arg = ~arg; rsp_kind = 2'd0; rsp_timeout = 16'd1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);

    got = '0;
    for (int i = 0; i < tx_log.size() && i < 48; i++) got[47-i] = tx_log[i];
    check(tx_log.size() == 48 && got == tok, {tag, " R2 token"}, 136'(got), 136'(tok));
    last_tok = got;
    check(timeout_err == exp_to, {tag, " R6 timeout"}, 136'(timeout_err), 136'(exp_to));
    check(crc_err == exp_ce, {tag, " R9 crc"}, 136'(crc_err), 136'(exp_ce));
    if (kind != 0 && !exp_to)
      check(rsp_data == rv, {tag, (kind == 3) ? " R8 long capture" : " R7 short capture"},
            rsp_data, rv);
    card_active = 0; card_armed = 0; consumed = 0; cq.delete();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cmd_oe == 1 && cmd_out == 1, "R1 reset line", 136'({cmd_oe, cmd_out}), 136'(3));
    check(!busy && !done, "R1 reset busy/done", 136'({busy, done}), 136'(0));
    check(!timeout_err && !crc_err && rsp_data == 0, "R1 reset flags", rsp_data, 136'(0));
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 R3: no reply, known CRC for index 0 argument 0
    run(6'd0, 32'h0, 2'd0, 16'd4, 0, 0, 0, 0, 0, "T1");
    check(last_tok[7:1] == 7'h4A, "R2 crc7 of idx0", 136'(last_tok[7:1]), 136'(7'h4A));
    check(cmd_oe == 1, "R3 no-reply keeps drive", 136'(cmd_oe), 136'(1));
    run(6'd17, 32'h0, 2'd0, 16'd4, 0, 0, 0, 0, 1, "T1b");
    check(last_tok[7:1] == 7'h2A, "R2 crc7 of idx17", 136'(last_tok[7:1]), 136'(7'h2A));

    // R4 R5 R7 R9: short replies
    run(6'd17, 32'h1234_5678, 2'd1, 16'd8, 3, 0, 0, 0, 1, "T2 R5");
    run(6'd13, 32'hCAFE_0042, 2'd1, 16'd8, 0, 1, 0, 0, 2, "T3 R9");
    run(6'd41, 32'h0F0F_A5A5, 2'd2, 16'd8, 2, 1, 0, 0, 0, "T4 R4");

    // R8 R10: long replies
    run(6'd2, 32'h8765_4321, 2'd3, 16'd8, 0, 0, 0, 0, 1, "T5 R10");
    run(6'd9, 32'hDEAD_BEEF, 2'd3, 16'd8, 1, 1, 0, 0, 2, "T6 R10");

    // R6: timeout and its edge
    run(6'd55, 32'h1, 2'd1, 16'd5, 0, 0, 1, 0, 0, "T7 R6 silent");
    run(6'd8, 32'h0000_01AA, 2'd1, 16'd5, 4, 0, 0, 0, 1, "T8 R6 edge ok");
    run(6'd8, 32'h0000_01AA, 2'd1, 16'd5, 5, 0, 0, 0, 0, "T8b R6 edge late");
    run(6'd3, 32'h7777_0000, 2'd1, 16'd0, 0, 0, 0, 0, 2, "T9 R6 zero ok");
    run(6'd3, 32'h7777_0000, 2'd3, 16'd0, 1, 0, 0, 0, 0, "T9b R6 zero late");

    // R11: start while busy ignored
    run(6'd24, 32'h3C3C_9999, 2'd1, 16'd8, 1, 0, 0, 1, 1, "T10 R11");
    check(rsp_data[45:40] == 6'd24, "R11 reply echoed index", 136'(rsp_data[45:40]), 136'(24));

    fin = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule